// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counting interval timer reached through a small register bus with separate read and write strobes, a byte address and a 16-bit data word. Software programs a prescale exponent, a mode and a modulus, then enables the counter. The counter steps down on a tick derived from the system clock. That clock is first halved, then divided by a power of two. When a tick finds the counter at zero, the timer expires. Expiry sets a sticky flag, reloads the counter and, when the interrupt enable is set, drives the interrupt output high.

Two reload behaviours are available. In reload mode the counter restarts from the stored modulus. In free-running mode it restarts from 0xFFFF. An overwrite option makes a modulus write load the counter at once instead of waiting for the next reload. A control write that only touches the interrupt enable, or only clears the flag, leaves the running count alone. Any other control write restarts the timer from a fresh reload. Two further control bits, debug-halt and doze-stop, are held and read back but have no effect.

Top module: `pit_timer`

## Requirements
- R1: After reset the control, modulus and count registers read zero and `irq` is low.
- R2: The control register is at offset 0x0, the modulus at 0x2 and the count at 0x4. Control bit fields: [0] enable, [1] reload mode, [2] expiry flag, [3] interrupt enable, [4] overwrite, [5] debug-halt, [6] doze-stop, [11:8] prescale exponent PRE. Bits 7 and 15:12 read as zero.
- R3: While enabled, the counter decrements once every 2·2^PRE clock cycles. The first step after a restart comes that many cycles after the restarting write. Expiry happens on the tick that finds the count at zero, so one period from a load of M lasts 2·2^PRE·(M+1) cycles.
- R4: On expiry the counter reloads from the modulus in reload mode (bit 1 set) and from 0xFFFF in free-running mode.
- R5: Writing 1 to control bit 2 clears the expiry flag. Writing 0 there leaves it unchanged. The flag is set only by expiry.
- R6: `irq` is high exactly when the expiry flag and the interrupt enable are both set.
- R7: A control write whose bits 0, 1, 4, 5, 6 and 11:8 match the stored values only updates the interrupt enable and the flag. It does not reload, pause or re-phase the count.
- R8: Any other control write stores the new settings and reloads the counter (modulus in reload mode, 0xFFFF otherwise). It restarts the prescaler and counts only if bit 0 is set.
- R9: With overwrite set, a modulus write loads the counter in the same cycle. With overwrite clear, the new modulus is used only at the next reload.
- R10: Writes to the count register are ignored.
- R11: When expiry and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R12: While disabled, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The expiry that sets the flag and a software write that clears it can land on the same clock edge. The bench arranges this by configuring PRE = 0 and a modulus of 1, which makes expiry fall four cycles after the restarting write. It then issues a flag-clearing control write with unchanged settings so that it lands on exactly that edge. The result is judged right when the flag and `irq` read high after that edge, and when a second clear one cycle later drops both. The next expiry must still arrive four cycles after the previous one, which shows the write did not re-phase the count.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int DW    = 16,
  parameter int PRE_W = 4,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PSW = (1 << PRE_W) - 1;
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_MOD = AW'(2);
  localparam logic [AW-1:0] A_CNT = AW'(4);

  logic             en, rld, flag, ie, ovw, halt, doze;
  logic [PRE_W-1:0] pre;
  logic [DW-1:0]    mod, cnt;
  logic             half;
  logic [PSW-1:0]   ps;

  logic wr_ctl, wr_mod, wr_cnt, cfg_same, ie_only, restart, ovw_load;
  logic base, ps_last, tick, expire;
  logic [PSW-1:0] ps_mask;
  logic [DW-1:0]  reload_val;
  logic unused_bits;

  assign wr_ctl   = wr_en && addr == A_CTL;
  assign wr_mod   = wr_en && addr == A_MOD;
  assign wr_cnt   = wr_en && addr == A_CNT;
  assign cfg_same = wdata[0] == en && wdata[1] == rld && wdata[4] == ovw &&
                    wdata[5] == halt && wdata[6] == doze && wdata[8 +: PRE_W] == pre;
  assign ie_only  = wr_ctl && cfg_same;
  assign restart  = wr_ctl && !cfg_same;
  assign ovw_load = wr_mod && ovw;

  assign ps_mask    = ~({PSW{1'b1}} << pre);
  assign base       = en && half;
  assign ps_last    = ps == ps_mask;
  assign tick       = base && ps_last;
  assign expire     = tick && cnt == '0 && !restart && !ovw_load;
  assign reload_val = rld ? mod : '1;
  assign irq        = flag && ie;
  assign unused_bits = ^{wdata[7], wdata[DW-1:8+PRE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en, rld, flag, ie, ovw, halt, doze} <= '0;
      pre  <= '0;
      mod  <= '0;
      cnt  <= '0;
      half <= 1'b0;
      ps   <= '0;
    end else begin
      if (wr_ctl) ie <= wdata[3];
      if (restart) begin
        en   <= wdata[0];
        rld  <= wdata[1];
        ovw  <= wdata[4];
        halt <= wdata[5];
        doze <= wdata[6];
        pre  <= wdata[8 +: PRE_W];
        half <= 1'b0;
        ps   <= '0;
        cnt  <= wdata[1] ? mod : '1;
      end else begin
        if (en) half <= ~half;
        if (base) ps <= ps_last ? '0 : ps + PSW'(1);
        if (ovw_load) cnt <= wdata;
        else if (tick) cnt <= (cnt == '0) ? reload_val : cnt - DW'(1);
      end
      if (wr_mod) mod <= wdata;
      flag <= expire || (flag && !(wr_ctl && wdata[2]));
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTL:   rdata = DW'({pre, 1'b0, doze, halt, ovw, ie, flag, rld, en});
        A_MOD:   rdata = mod;
        A_CNT:   rdata = cnt;
        default: rdata = '0;
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !restart && !ovw_load) |=> cnt == $past(cnt) - DW'(1)); // R3
  AST_RELOAD_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rld && !wr_mod) |=> cnt == mod); // R4
  AST_RELOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rld) |=> cnt == '1); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_ctl && wdata[2])) |=> flag); // R5
  AST_IE_ONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_only && !tick) |=> $stable(cnt) && $stable(pre)); // R7
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && wdata[1]) |=> cnt == mod); // R8
  AST_OVW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_load |=> cnt == $past(wdata)); // R9
  AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick) |=> $stable(cnt)); // R10
  AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R11
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt)); // R12
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [2:0] CTL = 3'h0, MODR = 3'h2, CNT = 3'h4;

  // fields: PRE[39:32], modulus[31:16], cycles to expiry 2*2^PRE*(M+1) [15:0]
  localparam logic [39:0] VEC [0:4] = '{
    {8'd0, 16'd3, 16'd8},
    {8'd1, 16'd2, 16'd12},
    {8'd2, 16'd1, 16'd16},
    {8'd0, 16'd0, 16'd2},
    {8'd3, 16'd0, 16'd16}
  };

  pit_timer u_dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(CTL, v);  chk("R1 ctl", v, 0);
    rd(MODR, v); chk("R1 mod", v, 0);
    rd(CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 irq", irq, 0);

    wr(CTL, 16'h0F72); rd(CTL, v); chk("R2 readback", v, 16'h0F72);
    wr(CTL, 16'hF0BA); rd(CTL, v); chk("R2 reserved bits", v, 16'h003A);
    wr(CTL, 16'h0004);

    for (int i = 0; i < 5; i++) begin
      logic [15:0] m;
      int p, n;
      p = int'(VEC[i][39:32]); m = VEC[i][31:16]; n = int'(VEC[i][15:0]);
      wr(MODR, m);
      wr(CTL, 16'h000B | 16'(p << 8));
      repeat (n - 1) @(negedge clk);
      rd(CTL, v); chk("R3 flag before expiry", int'(v[2]), 0);
      @(negedge clk);
      rd(CTL, v); chk("R3 flag at expiry", int'(v[2]), 1);
      chk("R6 irq at expiry", irq, 1);
      rd(CNT, v); chk("R4 reload from modulus", v, m);
      wr(CTL, 16'h0004);
    end

    wr(MODR, 16'h0050); wr(CTL, 16'h0002);
    repeat (10) @(negedge clk);
    rd(CNT, v); chk("R12 hold while off", v, 16'h0050);
    wr(CNT, 16'h1234);
    rd(CNT, v); chk("R10 count write ignored", v, 16'h0050);

    wr(MODR, 16'd5); wr(CTL, 16'h0103);
    repeat (3) @(negedge clk);
    rd(CNT, v); chk("R3 before first step", v, 5);
    @(negedge clk);
    rd(CNT, v); chk("R3 first step", v, 4);

    wr(MODR, 16'd20); wr(CTL, 16'h0003);
    repeat (6) @(negedge clk);
    rd(CNT, v); chk("R7 count before ie write", v, 17);
    wr(CTL, 16'h000B);
    rd(CNT, v); chk("R7 no reload", v, 17);
    rd(CTL, v); chk("R7 ie stored", v, 16'h000B);
    @(negedge clk);
    rd(CNT, v); chk("R7 phase kept", v, 16);

    wr(CTL, 16'h010B);
    rd(CNT, v); chk("R8 reload on config write", v, 20);
    repeat (3) @(negedge clk);
    rd(CNT, v); chk("R8 prescaler restarted", v, 20);
    @(negedge clk);
    rd(CNT, v); chk("R8 first step", v, 19);
    wr(CTL, 16'h000A);
    repeat (5) @(negedge clk);
    rd(CNT, v); chk("R8 stopped when disabled", v, 20);

    wr(CTL, 16'h0013);
    wr(MODR, 16'd3);
    rd(CNT, v); chk("R9 overwrite loads now", v, 3);
    wr(CTL, 16'h0003);
    wr(MODR, 16'd9);
    rd(CNT, v); chk("R9 no overwrite keeps count", v, 3);
    repeat (7) @(negedge clk);
    rd(CNT, v); chk("R9 new modulus at reload", v, 9);
    rd(CTL, v); chk("R9 flag at reload", int'(v[2]), 1);

    wr(CTL, 16'h0015);
    wr(MODR, 16'd1);
    repeat (2) @(negedge clk);
    rd(CNT, v); chk("R4 free before expiry", v, 0);
    rd(CTL, v); chk("R4 flag cleared by restart", int'(v[2]), 0);
    @(negedge clk);
    rd(CNT, v); chk("R4 free reload", v, 16'hFFFF);
    rd(CTL, v); chk("R4 free flag", int'(v[2]), 1);

    wr(CTL, 16'h0011);
    rd(CTL, v); chk("R5 zero write keeps flag", v, 16'h0015);
    chk("R6 irq masked", irq, 0);
    wr(CTL, 16'h0019);
    chk("R6 irq enabled", irq, 1);
    wr(CTL, 16'h001D);
    rd(CTL, v); chk("R5 one clears flag", int'(v[2]), 0);
    chk("R6 irq after clear", irq, 0);

    wr(MODR, 16'd1);
    wr(CTL, 16'h000F);
    repeat (3) @(negedge clk);
    wr(CTL, 16'h000F);
    rd(CTL, v); chk("R11 expiry beats clear", int'(v[2]), 1);
    chk("R11 irq", irq, 1);
    rd(CNT, v); chk("R11 reloaded", v, 1);
    wr(CTL, 16'h000F);
    rd(CTL, v); chk("R11 later clear", int'(v[2]), 0);
    repeat (2) @(negedge clk);
    rd(CTL, v); chk("R11 no early expiry", int'(v[2]), 0);
    @(negedge clk);
    rd(CTL, v); chk("R11 next expiry on time", int'(v[2]), 1);

    done = 1;
    finish_run();
  end
endmodule